// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor request port and a cache controller queue. It records every memory request that is in flight, one entry per cache line. Write-class requests (stores, read-modify-write halves and locked accesses) sit in one table. Read-class requests (loads and instruction fetches) sit in another. Each request is answered in the same cycle with a status. An accepted request gets a fresh ID and is forwarded to the controller on the next cycle.

When the controller signals a completion, it names the line and the table. The matching entry is freed and its ID is returned one cycle later. A completion that matches no entry raises a protocol-error pulse instead. Requests refused because their line is already pending are counted, split by the kind of the pending entry and the kind of the incoming request. While anything is in flight, a periodic watchdog looks for entries whose age has reached a threshold. If it finds one, it sets a sticky deadlock flag.

Top module: `mem_req_tracker`

## Requirements
- R1: Kind codes are: load 0, fetch 1, store 2, RMW-read 3, RMW-write 4, locked-read 5, locked-write 6. Codes 0 and 1 go to the read table. Every other code goes to the write table. A completion must name the right table with cpl_write_i (1 for the write table); a completion naming the other table does not match.
- R2: The line address is req_addr_i with its low OFF_W bits dropped. A request whose line matches any pending entry in either table gets status 1 (aliased), is not forwarded and allocates nothing. An entry being freed in the same cycle still counts as pending.
- R3: A request that is not aliased gets status 2 (full) in two cases: when the in-flight count already equals MAX_OUT, or when its target table already holds DEPTH entries. The count used is the one before any same-cycle completion.
- R4: A request whose byte offset plus req_len_i exceeds 2^OFF_W gets status 3 (size error). A request ending exactly at the block boundary is legal. Precedence is size error, then aliased, then full.
- R5: An accepted request gets status 0. req_id_o shows its ID in that cycle. On the next cycle fwd_valid_o pulses with its kind, line and ID. IDs start at 0 after reset and rise by one per accepted request, wrapping at 2^ID_W.
- R6: inflight_o equals the number of table entries. It rises by one per accept and falls by one per matched completion. An accept and a completion in the same cycle leave it unchanged. It is 0 after reset.
- R7: A completion that matches an entry pulses cpl_done_o on the next cycle with that entry's ID on cpl_id_o. The line is then free for new requests.
- R8: A completion that matches no entry pulses proto_err_o on the next cycle and leaves the tables unchanged.
- R9: An aliased request whose line is pending in the write table increments stall_wr_rd_o if its kind is load, fetch or RMW-read. Any other kind increments stall_wr_oth_o.
- R10: An aliased request whose line is pending in the read table increments stall_rd_wr_o if its kind is store or RMW-write. Any other kind increments stall_rd_oth_o.
- R11: While inflight_o is nonzero, the block checks all entries once every THRESH cycles. deadlock_o is set if any entry is at least THRESH cycles old, and stays set until reset. The check timer restarts whenever nothing is in flight. deadlock_o is never set while every entry is younger than THRESH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | New request presented |
| req_kind_i | input | 3 | Request kind code |
| req_addr_i | input | ADDR_W | Physical byte address |
| req_len_i | input | LEN_W | Access length in bytes |
| req_status_o | output | 2 | Same-cycle answer: 0 ok, 1 aliased, 2 full, 3 size error |
| req_id_o | output | ID_W | ID given to the request if accepted |
| fwd_valid_o | output | 1 | Forward pulse to controller queue |
| fwd_kind_o | output | 3 | Forwarded kind |
| fwd_line_o | output | ADDR_W-OFF_W | Forwarded line address |
| fwd_id_o | output | ID_W | Forwarded ID |
| cpl_valid_i | input | 1 | Completion from controller |
| cpl_write_i | input | 1 | Completion targets write table |
| cpl_line_i | input | ADDR_W-OFF_W | Completed line |
| cpl_done_o | output | 1 | Matched completion pulse |
| cpl_id_o | output | ID_W | ID of freed entry |
| proto_err_o | output | 1 | Unmatched completion pulse |
| inflight_o | output | clog2(2*DEPTH+1) | Requests in flight |
| stall_wr_rd_o | output | STALL_W | Read-like blocked by pending write |
| stall_wr_oth_o | output | STALL_W | Other kind blocked by pending write |
| stall_rd_wr_o | output | STALL_W | Store-like blocked by pending read |
| stall_rd_oth_o | output | STALL_W | Other kind blocked by pending read |
| deadlock_o | output | 1 | Sticky stuck-request flag |

## Verification
The bench sends requests on the same cycle as a completion for the same line. A design that freed the entry before its alias check would accept a second request to that line. It fills one table while the other still has room, and a design that checked only the global limit would overrun the table. It also presents a completion naming the wrong table, which a design that searched both tables would wrongly accept. Access lengths land exactly on and one past the block boundary, which catches an off-by-one in the size check. The watchdog is first tested under heavy random traffic where no entry may trip it, then with a single request left open, checked both before and after the second check period.

// File: rtl/mrt_pkg.sv
`timescale 1ns/1ps
package mrt_pkg;
  typedef enum logic [2:0] {
    K_LOAD = 3'd0, K_IFETCH = 3'd1, K_STORE = 3'd2, K_RMW_RD = 3'd3,
    K_RMW_WR = 3'd4, K_LCK_RD = 3'd5, K_LCK_WR = 3'd6
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_ALIAS = 2'd1, ST_FULL = 2'd2, ST_SIZE = 2'd3
  } req_stat_e;

  function automatic logic kind_is_write(input logic [2:0] k);
    return !(k == K_LOAD || k == K_IFETCH);
  endfunction
endpackage

// File: rtl/mrt_cam.sv
`timescale 1ns/1ps
module mrt_cam #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int ID_W   = 8,
  parameter int THRESH = 64,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              look_hit_o,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic [ID_W-1:0]   alloc_id_i,
  input  logic              free_i,
  input  logic [LINE_W-1:0] free_line_i,
  output logic              free_hit_o,
  output logic [ID_W-1:0]   free_id_o,
  output logic              full_o,
  output logic [OCC_W-1:0]  count_o,
  output logic              old_o
);
  localparam int AGE_W = $clog2(THRESH + 1);

  logic [DEPTH-1:0]  vld_q, look_vec, free_vec, old_vec, alloc_sel;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];

  // lowest free slot takes the allocation
  always_comb begin
    logic found;
    found = 1'b0;
    alloc_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        alloc_sel[i] = 1'b1;
        found = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign look_vec[g] = vld_q[g] && (line_q[g] == look_line_i);
    assign free_vec[g] = vld_q[g] && (line_q[g] == free_line_i);
    assign old_vec[g]  = vld_q[g] && (age_q[g] >= AGE_W'(THRESH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        line_q[g] <= '0;
        id_q[g]   <= '0;
        age_q[g]  <= '0;
      end else if (alloc_i && alloc_sel[g]) begin
        vld_q[g]  <= 1'b1;
        line_q[g] <= alloc_line_i;
        id_q[g]   <= alloc_id_i;
        age_q[g]  <= '0;
      end else begin
        if (free_i && free_vec[g]) vld_q[g] <= 1'b0;
        if (vld_q[g] && age_q[g] < AGE_W'(THRESH)) age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    free_id_o = '0;
    count_o   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_vec[i]) free_id_o = free_id_o | id_q[i];
      count_o = count_o + OCC_W'(vld_q[i]);
    end
  end

  assign look_hit_o = |look_vec;
  assign free_hit_o = |free_vec;
  assign full_o     = &vld_q;
  assign old_o      = |old_vec;
endmodule

// File: rtl/mrt_watchdog.sv
`timescale 1ns/1ps
module mrt_watchdog #(
  parameter int THRESH = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic any_old_i,
  output logic deadlock_o
);
  localparam int TMR_W = $clog2(THRESH);

  logic [TMR_W-1:0] tmr_q;
  logic             dl_q;
  logic             tick;

  assign tick = busy_i && (tmr_q == TMR_W'(THRESH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      dl_q  <= 1'b0;
    end else begin
      if (!busy_i || tick) tmr_q <= '0;
      else                 tmr_q <= tmr_q + 1'b1;
      if (tick && any_old_i) dl_q <= 1'b1;
    end
  end

  assign deadlock_o = dl_q;
endmodule

// File: rtl/mem_req_tracker.sv
`timescale 1ns/1ps
module mem_req_tracker #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int LEN_W   = 5,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 6,
  parameter int ID_W    = 8,
  parameter int STALL_W = 16,
  parameter int THRESH  = 64,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int CNT_W  = $clog2(2 * DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2:0]         req_kind_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  output logic [1:0]         req_status_o,
  output logic [ID_W-1:0]    req_id_o,
  output logic               fwd_valid_o,
  output logic [2:0]         fwd_kind_o,
  output logic [LINE_W-1:0]  fwd_line_o,
  output logic [ID_W-1:0]    fwd_id_o,
  input  logic               cpl_valid_i,
  input  logic               cpl_write_i,
  input  logic [LINE_W-1:0]  cpl_line_i,
  output logic               cpl_done_o,
  output logic [ID_W-1:0]    cpl_id_o,
  output logic               proto_err_o,
  output logic [CNT_W-1:0]   inflight_o,
  output logic [STALL_W-1:0] stall_wr_rd_o,
  output logic [STALL_W-1:0] stall_wr_oth_o,
  output logic [STALL_W-1:0] stall_rd_wr_o,
  output logic [STALL_W-1:0] stall_rd_oth_o,
  output logic               deadlock_o
);
  import mrt_pkg::*;

  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int SUM_W = ((OFF_W + 1) > LEN_W ? (OFF_W + 1) : LEN_W) + 1;

  logic [LINE_W-1:0] req_line;
  logic              req_wr, size_bad, alias_hit, no_room, accept, free_ok;
  logic              hit_w, hit_r, full_w, full_r, fh_w, fh_r, old_w, old_r;
  logic [ID_W-1:0]   fid_w, fid_r;
  logic [OCC_W-1:0]  occ_w, occ_r;
  logic [SUM_W-1:0]  end_byte;
  req_stat_e         stat;

  logic [ID_W-1:0]    id_q;
  logic [CNT_W-1:0]   inflight_q;
  logic               fwd_v_q, done_q, perr_q;
  logic [2:0]         fwd_k_q;
  logic [LINE_W-1:0]  fwd_l_q;
  logic [ID_W-1:0]    fwd_id_q, cid_q;
  logic [STALL_W-1:0] st_wr_rd_q, st_wr_oth_q, st_rd_wr_q, st_rd_oth_q;

  assign req_line  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_wr    = kind_is_write(req_kind_i);
  assign end_byte  = SUM_W'(req_addr_i[OFF_W-1:0]) + SUM_W'(req_len_i);
  assign size_bad  = end_byte > SUM_W'(1 << OFF_W);
  assign alias_hit = hit_w || hit_r;
  assign no_room   = (inflight_q >= CNT_W'(MAX_OUT)) || (req_wr ? full_w : full_r);

  always_comb begin
    if (size_bad)       stat = ST_SIZE;
    else if (alias_hit) stat = ST_ALIAS;
    else if (no_room)   stat = ST_FULL;
    else                stat = ST_OK;
  end

  assign accept  = req_valid_i && (stat == ST_OK);
  assign free_ok = cpl_valid_i && (cpl_write_i ? fh_w : fh_r);

  mrt_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .THRESH(THRESH)) u_cam_w (
    .clk_i, .rst_ni,
    .look_line_i (req_line),   .look_hit_o (hit_w),
    .alloc_i     (accept && req_wr), .alloc_line_i (req_line), .alloc_id_i (id_q),
    .free_i      (cpl_valid_i && cpl_write_i), .free_line_i (cpl_line_i),
    .free_hit_o  (fh_w), .free_id_o (fid_w),
    .full_o      (full_w), .count_o (occ_w), .old_o (old_w)
  );

  mrt_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .THRESH(THRESH)) u_cam_r (
    .clk_i, .rst_ni,
    .look_line_i (req_line),   .look_hit_o (hit_r),
    .alloc_i     (accept && !req_wr), .alloc_line_i (req_line), .alloc_id_i (id_q),
    .free_i      (cpl_valid_i && !cpl_write_i), .free_line_i (cpl_line_i),
    .free_hit_o  (fh_r), .free_id_o (fid_r),
    .full_o      (full_r), .count_o (occ_r), .old_o (old_r)
  );

  mrt_watchdog #(.THRESH(THRESH)) u_wdog (
    .clk_i, .rst_ni,
    .busy_i     (inflight_q != '0),
    .any_old_i  (old_w || old_r),
    .deadlock_o (deadlock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q        <= '0;
      inflight_q  <= '0;
      fwd_v_q     <= 1'b0;
      fwd_k_q     <= '0;
      fwd_l_q     <= '0;
      fwd_id_q    <= '0;
      done_q      <= 1'b0;
      perr_q      <= 1'b0;
      cid_q       <= '0;
      st_wr_rd_q  <= '0;
      st_wr_oth_q <= '0;
      st_rd_wr_q  <= '0;
      st_rd_oth_q <= '0;
    end else begin
      fwd_v_q    <= accept;
      done_q     <= free_ok;
      perr_q     <= cpl_valid_i && !free_ok;
      inflight_q <= inflight_q + CNT_W'(accept) - CNT_W'(free_ok);
      if (accept) begin
        id_q     <= id_q + 1'b1;
        fwd_k_q  <= req_kind_i;
        fwd_l_q  <= req_line;
        fwd_id_q <= id_q;
      end
      if (free_ok) cid_q <= cpl_write_i ? fid_w : fid_r;
      if (req_valid_i && stat == ST_ALIAS) begin
        if (hit_w) begin
          if (req_kind_i == K_LOAD || req_kind_i == K_IFETCH || req_kind_i == K_RMW_RD)
            st_wr_rd_q <= st_wr_rd_q + 1'b1;
          else
            st_wr_oth_q <= st_wr_oth_q + 1'b1;
        end else begin
          if (req_kind_i == K_STORE || req_kind_i == K_RMW_WR)
            st_rd_wr_q <= st_rd_wr_q + 1'b1;
          else
            st_rd_oth_q <= st_rd_oth_q + 1'b1;
        end
      end
    end
  end

  assign req_status_o   = stat;
  assign req_id_o       = id_q;
  assign fwd_valid_o    = fwd_v_q;
  assign fwd_kind_o     = fwd_k_q;
  assign fwd_line_o     = fwd_l_q;
  assign fwd_id_o       = fwd_id_q;
  assign cpl_done_o     = done_q;
  assign cpl_id_o       = cid_q;
  assign proto_err_o    = perr_q;
  assign inflight_o     = inflight_q;
  assign stall_wr_rd_o  = st_wr_rd_q;
  assign stall_wr_oth_o = st_wr_oth_q;
  assign stall_rd_wr_o  = st_rd_wr_q;
  assign stall_rd_oth_o = st_rd_oth_q;
endmodule

// File: rtl/mrt_chk.sv
`timescale 1ns/1ps
module mrt_chk #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int LEN_W   = 5,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 6,
  localparam int CNT_W  = $clog2(2 * DEPTH + 1),
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [LEN_W-1:0]  req_len_i,
  input logic [1:0]        req_status_o,
  input logic              fwd_valid_o,
  input logic              cpl_valid_i,
  input logic              proto_err_o,
  input logic [CNT_W-1:0]  inflight_o,
  input logic [OCC_W-1:0]  occ_w,
  input logic [OCC_W-1:0]  occ_r,
  input logic              deadlock_o
);
  // R6
  occ_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_o == CNT_W'(occ_w) + CNT_W'(occ_r));

  // R3
  cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_o <= CNT_W'(MAX_OUT));

  // R5
  fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_status_o == 2'd0) |=> fwd_valid_o);

  // R2
  alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_status_o == 2'd1 && !cpl_valid_i) |=> inflight_o == $past(inflight_o));

  // R4
  size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (32'(req_addr_i[OFF_W-1:0]) + 32'(req_len_i) > (32'd1 << OFF_W)))
      |-> req_status_o == 2'd3);

  // R8
  perr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(cpl_valid_i));

  // R11
  dl_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |=> deadlock_o);

  // R11
  dl_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deadlock_o) |-> $past(inflight_o) != '0);
endmodule

bind mem_req_tracker mrt_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_len_i(req_len_i), .req_status_o(req_status_o), .fwd_valid_o(fwd_valid_o),
  .cpl_valid_i(cpl_valid_i), .proto_err_o(proto_err_o), .inflight_o(inflight_o),
  .occ_w(occ_w), .occ_r(occ_r), .deadlock_o(deadlock_o)
);

// File: tb/mem_req_tracker_tb.sv
`timescale 1ns/1ps
module mem_req_tracker_tb;
  import mrt_pkg::*;

  localparam int MAX_OUT = 6;
  localparam int DEPTH   = 4;
  localparam int THRESH  = 64;
  localparam int NSLOT   = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, cpl_valid = 1'b0, cpl_write = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic [11:0] cpl_line = '0;
  logic [1:0]  req_status;
  logic [7:0]  req_id, fwd_id, cpl_id;
  logic        fwd_valid, cpl_done, proto_err, deadlock;
  logic [2:0]  fwd_kind;
  logic [11:0] fwd_line;
  logic [3:0]  inflight;
  logic [15:0] s_wr_rd, s_wr_oth, s_rd_wr, s_rd_oth;

  always #2.5 clk = ~clk;

  mem_req_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_status_o(req_status), .req_id_o(req_id),
    .fwd_valid_o(fwd_valid), .fwd_kind_o(fwd_kind), .fwd_line_o(fwd_line), .fwd_id_o(fwd_id),
    .cpl_valid_i(cpl_valid), .cpl_write_i(cpl_write), .cpl_line_i(cpl_line),
    .cpl_done_o(cpl_done), .cpl_id_o(cpl_id), .proto_err_o(proto_err), .inflight_o(inflight),
    .stall_wr_rd_o(s_wr_rd), .stall_wr_oth_o(s_wr_oth), .stall_rd_wr_o(s_rd_wr),
    .stall_rd_oth_o(s_rd_oth), .deadlock_o(deadlock)
  );

  int checks = 0, errors = 0;
  bit chk_dl = 1'b1;

  bit         m_v   [NSLOT];
  bit         m_w   [NSLOT];
  logic [11:0] m_line[NSLOT];
  logic [7:0] m_id  [NSLOT];
  int         m_age [NSLOT];
  int         m_cnt = 0;
  logic [7:0] m_next_id = '0;
  logic [15:0] m_st [4];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit is_wr(input logic [2:0] k);
    return !(k == 3'd0 || k == 3'd1);
  endfunction

  function automatic int find_line(input logic [11:0] l);
    for (int i = 0; i < NSLOT; i++) if (m_v[i] && m_line[i] == l) return i;
    return -1;
  endfunction

  function automatic int tbl_cnt(input bit w);
    int n = 0;
    for (int i = 0; i < NSLOT; i++) if (m_v[i] && m_w[i] == w) n++;
    return n;
  endfunction

  function automatic int exp_status(input logic [2:0] k, input logic [15:0] a, input logic [4:0] l);
    if (int'(a[3:0]) + int'(l) > 16) return 3;
    if (find_line(a[15:4]) >= 0) return 1;
    if (m_cnt >= MAX_OUT || tbl_cnt(is_wr(k)) >= DEPTH) return 2;
    return 0;
  endfunction

  task automatic step(input bit rv, input logic [2:0] k, input logic [15:0] a, input logic [4:0] l,
                      input bit cv, input bit cw, input logic [11:0] cl);
    int es, ci, ai;
    bit e_done, e_perr;
    logic [7:0] e_cid, e_fid;
    string stag [4] = '{"R5", "R2", "R3", "R4"};
    @(negedge clk);
    req_valid = rv; req_kind = k; req_addr = a; req_len = l;
    cpl_valid = cv; cpl_write = cw; cpl_line = cl;
    #1;
    es = rv ? exp_status(k, a, l) : -1;
    if (rv) chk({stag[es], " status"}, req_status, es);
    e_fid = m_next_id;
    if (es == 0) chk("R5 id", req_id, m_next_id);
    ci = -1;
    if (cv) for (int i = 0; i < NSLOT; i++) if (m_v[i] && m_line[i] == cl && m_w[i] == cw) ci = i;
    e_done = cv && ci >= 0;
    e_perr = cv && ci < 0;
    e_cid  = (ci >= 0) ? m_id[ci] : '0;
    if (es == 1) begin
      ai = find_line(a[15:4]);
      if (m_w[ai]) begin
        if (k == 3'd0 || k == 3'd1 || k == 3'd3) m_st[0]++; else m_st[1]++;
      end else begin
        if (k == 3'd2 || k == 3'd4) m_st[2]++; else m_st[3]++;
      end
    end
    for (int i = 0; i < NSLOT; i++) if (m_v[i]) m_age[i]++;
    if (ci >= 0) begin m_v[ci] = 1'b0; m_cnt--; end
    if (es == 0) begin
      for (int i = 0; i < NSLOT; i++) if (!m_v[i]) begin
        m_v[i] = 1'b1; m_w[i] = is_wr(k); m_line[i] = a[15:4]; m_id[i] = m_next_id; m_age[i] = 0;
        break;
      end
      m_cnt++;
      m_next_id++;
    end
    @(posedge clk);
    #1;
    chk("R5 fwd_valid", fwd_valid, es == 0);
    if (es == 0) begin
      chk("R5 fwd_id", fwd_id, e_fid);
      chk("R5 fwd_line", fwd_line, a[15:4]);
      chk("R1 fwd_kind", fwd_kind, k);
    end
    chk("R7 cpl_done", cpl_done, e_done);
    if (e_done) chk("R7 cpl_id", cpl_id, e_cid);
    chk(cv && ci < 0 && find_line(cl) >= 0 ? "R1 wrong-table proto_err" : "R8 proto_err",
        proto_err, e_perr);
    chk("R6 inflight", inflight, m_cnt);
    chk("R9 stall_wr_rd", s_wr_rd, m_st[0]);
    chk("R9 stall_wr_oth", s_wr_oth, m_st[1]);
    chk("R10 stall_rd_wr", s_rd_wr, m_st[2]);
    chk("R10 stall_rd_oth", s_rd_oth, m_st[3]);
    if (chk_dl) chk("R11 no deadlock while young", deadlock, 0);
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 16'h0, 5'd0, 1'b0, 1'b0, 12'h0);
  endtask

  task automatic drain();
    for (int i = 0; i < NSLOT; i++)
      if (m_v[i]) step(1'b0, 3'd0, 16'h0, 5'd0, 1'b1, m_w[i], m_line[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NSLOT; i++) m_v[i] = 1'b0;
    for (int i = 0; i < 4; i++) m_st[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset inflight", inflight, 0);
    chk("R5 reset fwd_valid", fwd_valid, 0);
    chk("R7 reset cpl_done", cpl_done, 0);
    chk("R11 reset deadlock", deadlock, 0);
    chk("R9 reset stall", s_wr_rd, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 size boundary
    step(1'b1, 3'd0, 16'h100F, 5'd2, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd0, 16'h1008, 5'd9, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd0, 16'h1008, 5'd8, 1'b0, 1'b0, 12'h0);
    // R4 size error wins over alias
    step(1'b1, 3'd2, 16'h100C, 5'd8, 1'b0, 1'b0, 12'h0);
    drain();
    // R3 write table fills before global limit
    for (int i = 0; i < 4; i++) step(1'b1, 3'd2, 16'h2000 + 16'(i * 16), 5'd4, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd6, 16'h2040, 5'd4, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd0, 16'h2100, 5'd4, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd1, 16'h2110, 5'd4, 1'b0, 1'b0, 12'h0);
    // R3 global limit
    step(1'b1, 3'd0, 16'h2120, 5'd4, 1'b0, 1'b0, 12'h0);
    // R9 / R10 alias pairings
    step(1'b1, 3'd0, 16'h2003, 5'd1, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd4, 16'h2015, 5'd1, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd2, 16'h2101, 5'd1, 1'b0, 1'b0, 12'h0);
    step(1'b1, 3'd1, 16'h2112, 5'd1, 1'b0, 1'b0, 12'h0);
    // R2 alias against a line freed in the same cycle
    step(1'b1, 3'd0, 16'h2000, 5'd1, 1'b1, 1'b1, 12'h200);
    // R1 completion naming the wrong table
    step(1'b0, 3'd0, 16'h0, 5'd0, 1'b1, 1'b1, 12'h210);
    // R8 unknown line
    step(1'b0, 3'd0, 16'h0, 5'd0, 1'b1, 1'b0, 12'hABC);
    drain();
    idle();

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit rv, cv, cw;
      logic [2:0] k;
      logic [15:0] a;
      logic [4:0] l;
      logic [11:0] cl;
      int old_i, old_a;
      rv = ($urandom % 3) != 0;
      k  = 3'($urandom % 7);
      a  = {12'h040 + 12'($urandom % 10), 4'($urandom % 16)};
      l  = (($urandom % 6) == 0) ? 5'($urandom % 21) : 5'(1 + $urandom % 8);
      old_i = -1; old_a = -1;
      for (int i = 0; i < NSLOT; i++) if (m_v[i] && m_age[i] > old_a) begin old_a = m_age[i]; old_i = i; end
      cv = 1'b0; cw = 1'b0; cl = '0;
      if (old_i >= 0 && (($urandom % 2) == 0 || old_a > 30)) begin
        cv = 1'b1; cw = m_w[old_i]; cl = m_line[old_i];
        if (old_a <= 30 && ($urandom % 10) == 0) cw = !cw;
      end else if (($urandom % 20) == 0) begin
        cv = 1'b1; cw = 1'($urandom % 2); cl = 12'hF00 + 12'($urandom % 8);
      end
      step(rv, k, a, l, cv, cw, cl);
    end
    drain();
    idle();

    // R11 stuck request trips the watchdog on the second check
    step(1'b1, 3'd0, 16'h3000, 5'd4, 1'b0, 1'b0, 12'h0);
    chk_dl = 1'b0;
    for (int j = 1; j <= 2 * THRESH + 3; j++) begin
      idle();
      if (j == THRESH + 2) chk("R11 deadlock not yet", deadlock, 0);
      if (j == 2 * THRESH + 3) chk("R11 deadlock raised", deadlock, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule